// File: doc/BRIEF.md
# Multi-Format Serial PCM Receiver

This block takes a three-wire serial audio stream (bit clock, frame clock, data) and turns it into pairs of 24-bit two's-complement stereo samples. The serial wires are oversampled by a faster system clock. Each wire passes through a synchronizer, and the rising edges of the bit clock are found inside the system-clock domain. Every rising bit-clock edge samples one data bit and one frame-clock level.

A 3-bit format code selects one of six framings:

| Code | Framing | Where the sample sits |
|------|---------|-----------------------|
| 0 | left-justified | MSB on the first bit after the frame-clock change |
| 1 | I2S | MSB one bit later than left-justified |
| 2 | right-justified, 16 bits | LSB on the last bit before the next frame-clock change |
| 3 | right-justified, 24 bits | as code 2 |
| 4 | right-justified, 20 bits | as code 2 |
| 5 | right-justified, 18 bits | as code 2 |

Codes 6 and 7 are reserved. For the left-justified and I2S framings the sample is placed at the top of the 24-bit word. For the right-justified framings it is sign-extended. When a right-channel half-frame closes, the block presents the left and right samples together with a one-cycle strobe.

A three-state controller tracks alignment:
- `ST_WAIT` is entered from reset. It moves to `ST_ALIGN` on the first bit-clock edge, which records the frame-clock level.
- `ST_ALIGN` moves to `ST_RECV` on the first bit-clock edge whose frame-clock level differs from the one recorded, provided the format code is valid and unchanged.
- `ST_RECV` returns to `ST_ALIGN` whenever the format code changes or becomes reserved. It stays in `ST_RECV` otherwise.

Top module: `serial_pcm_rx`

## Requirements
- R1: While and right after reset, `valid_o` is 0 and `left_o` and `right_o` are all zeros.
- R2: Code 0 (left-justified): the bit sampled on the first rising bit-clock edge after a frame-clock change is the sample MSB (bit 23). Frame clock high marks the left channel.
- R3: Code 1 (I2S): the bit on the first rising edge after a frame-clock change is discarded and the next bit is the MSB. Frame clock low marks the left channel.
- R4: Codes 2, 3, 4 and 5 (right-justified at 16, 24, 20 and 18 bits): the last N bits of a half-frame form the sample, LSB last, and the sample is sign-extended from bit N-1 to 24 bits. Earlier bits of the half-frame have no effect. Frame clock high marks the left channel.
- R5: Codes 0 and 1: bits beyond the 24th sample bit of a half-frame are ignored. When a half-frame carries fewer than 24 sample bits, the missing low bits read as 0.
- R6: `valid_o` is high for exactly one system clock, one left-right pair per strobe. `left_o` and `right_o` change only in a cycle where `valid_o` is high.
- R7: The partial half-frame seen before the first frame-clock change after reset is discarded. A right half-frame that has no complete left half-frame before it produces no strobe.
- R8: With a reserved code (6 or 7) no strobe is produced and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock, oversampling the serial wires |
| rst_n | input | 1 | active-low synchronous reset |
| fmt_i | input | 3 | framing code, 0..5 valid |
| bclk_i | input | 1 | serial bit clock |
| lrclk_i | input | 1 | frame (channel) clock |
| sdata_i | input | 1 | serial data, MSB first |
| left_o | output | 24 | left sample of the last pair |
| right_o | output | 24 | right sample of the last pair |
| valid_o | output | 1 | one-cycle strobe for a new pair |

## Verification
Each of the six codes is driven with 32-bit half-frames. Bits outside the sample window are filled with ones, so a wrong bit offset or a leaking stale bit shows up as a changed value. Shorter half-frames (16, 20, 24 and 25 bits) separate the zero-fill and truncation rules of the justified framings from the keep-last-N rule of the right-justified framings. Negative and positive samples with different bit patterns in the left and right channels expose sign-extension errors and swapped channels. Further streams cover:
- a stream that opens in the middle of a right half-frame, which exercises the discard rule;
- a reserved code, which must leave the outputs untouched.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
    localparam int SAMPLE_W = 24;
    localparam int FMT_W    = 3;

    localparam logic [FMT_W-1:0] FMT_LJ   = 3'd0;
    localparam logic [FMT_W-1:0] FMT_I2S  = 3'd1;
    localparam logic [FMT_W-1:0] FMT_RJ16 = 3'd2;
    localparam logic [FMT_W-1:0] FMT_RJ24 = 3'd3;
    localparam logic [FMT_W-1:0] FMT_RJ20 = 3'd4;
    localparam logic [FMT_W-1:0] FMT_RJ18 = 3'd5;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RECV  = 2'd2
    } rx_state_e;

    function automatic logic fmt_ok(input logic [FMT_W-1:0] f);
        return f <= FMT_RJ18;
    endfunction

    function automatic logic fmt_is_rj(input logic [FMT_W-1:0] f);
        return (f >= FMT_RJ16) && (f <= FMT_RJ18);
    endfunction

    function automatic int rj_bits(input logic [FMT_W-1:0] f);
        case (f)
            FMT_RJ16: return 16;
            FMT_RJ24: return 24;
            FMT_RJ20: return 20;
            FMT_RJ18: return 18;
            default:  return 24;
        endcase
    endfunction

    // frame-clock level that marks the left channel
    function automatic logic left_level(input logic [FMT_W-1:0] f);
        return (f == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic sdata_i,
    output logic stb_o,
    output logic lr_o,
    output logic dat_o
);
    logic [STAGES-1:0] bclk_sr, lr_sr, dat_sr;
    logic              bclk_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sr   <= '0;
            lr_sr     <= '0;
            dat_sr    <= '0;
            bclk_last <= 1'b0;
        end else begin
            bclk_sr   <= {bclk_sr[STAGES-2:0], bclk_i};
            lr_sr     <= {lr_sr[STAGES-2:0], lrclk_i};
            dat_sr    <= {dat_sr[STAGES-2:0], sdata_i};
            bclk_last <= bclk_sr[STAGES-1];
        end
    end

    always_comb begin
        stb_o = bclk_sr[STAGES-1] & ~bclk_last;
        lr_o  = lr_sr[STAGES-1];
        dat_o = dat_sr[STAGES-1];
    end
endmodule

// File: rtl/pcm_frame_fsm.sv
module pcm_frame_fsm
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FMT_W-1:0] fmt_i,
    input  logic             stb_i,
    input  logic             lr_i,
    output logic             begin_o,
    output logic             take_o,
    output logic             done_o,
    output logic             done_left_o,
    output logic [CNT_W-1:0] idx_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    rx_state_e        state_q, state_n;
    logic             lr_prev_q;
    logic [FMT_W-1:0] fmt_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fmt_chg, lr_edge;

    assign fmt_chg = (fmt_i != fmt_q);
    assign lr_edge = stb_i && (lr_i != lr_prev_q) && (state_q != ST_WAIT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_WAIT;
            lr_prev_q <= 1'b0;
            fmt_q     <= '0;
            cnt_q     <= '0;
        end else begin
            state_q <= state_n;
            fmt_q   <= fmt_i;
            if (stb_i)  lr_prev_q <= lr_i;
            if (take_o) cnt_q     <= idx_o;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_WAIT:  if (stb_i) state_n = ST_ALIGN;
            ST_ALIGN: if (lr_edge && !fmt_chg && fmt_ok(fmt_i)) state_n = ST_RECV;
            ST_RECV:  if (fmt_chg || !fmt_ok(fmt_i)) state_n = ST_ALIGN;
            default:  state_n = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        begin_o     = lr_edge && !fmt_chg && fmt_ok(fmt_i);
        done_o      = lr_edge && (state_q == ST_RECV) && !fmt_chg && fmt_ok(fmt_i);
        take_o      = stb_i && !fmt_chg && fmt_ok(fmt_i) &&
                      ((state_q == ST_RECV) || begin_o);
        done_left_o = (lr_prev_q == left_level(fmt_i));
        if (begin_o)              idx_o = '0;
        else if (cnt_q == CNT_MAX) idx_o = CNT_MAX;
        else                      idx_o = cnt_q + 1'b1;
    end

    AST_RECV_VALID_FMT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV) |-> fmt_ok(fmt_q)); // R8
    AST_RECV_FROM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RECV) |-> $past(state_q) == ST_ALIGN); // R7
endmodule

// File: rtl/pcm_sample_asm.sv
module pcm_sample_asm
    import aud_rx_pkg::*;
#(
    parameter int W     = SAMPLE_W,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FMT_W-1:0] fmt_i,
    input  logic             bit_i,
    input  logic             begin_i,
    input  logic             take_i,
    input  logic             done_i,
    input  logic             done_left_i,
    input  logic [CNT_W-1:0] idx_i,
    output logic [W-1:0]     word_o,
    output logic             word_stb_o,
    output logic             word_left_o
);
    logic [W-1:0] acc_q, acc_n, shf_q, rj_word;
    int           pos, nbits;

    // MSB-first placement for left-justified and I2S
    always_comb begin
        acc_n = begin_i ? '0 : acc_q;
        pos   = int'(idx_i) - ((fmt_i == FMT_I2S) ? 1 : 0);
        if (!fmt_is_rj(fmt_i) && pos >= 0 && pos < W)
            acc_n[W-1-pos] = bit_i;
    end

    // sign extension of the last N shifted bits
    always_comb begin
        nbits = rj_bits(fmt_i);
        for (int i = 0; i < W; i++)
            rj_word[i] = (i < nbits) ? shf_q[i] : shf_q[nbits-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            shf_q       <= '0;
            word_o      <= '0;
            word_stb_o  <= 1'b0;
            word_left_o <= 1'b0;
        end else begin
            word_stb_o <= done_i;
            if (done_i) begin
                word_o      <= fmt_is_rj(fmt_i) ? rj_word : acc_q;
                word_left_o <= done_left_i;
            end
            if (take_i) begin
                acc_q <= acc_n;
                shf_q <= {shf_q[W-2:0], bit_i};
            end
        end
    end

    AST_WORD_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |-> $past(done_i)); // R6
    AST_DONE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> take_i && begin_i); // R2
endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_i,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    input  logic                sdata_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic                stb, lr_s, dat_s;
    logic                beg, take, done, done_left;
    logic [CNT_W-1:0]    idx;
    logic [SAMPLE_W-1:0] word;
    logic                word_stb, word_left;
    logic [SAMPLE_W-1:0] left_hold_q;
    logic                have_left_q;

    pcm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
        .sdata_i(sdata_i), .stb_o(stb), .lr_o(lr_s), .dat_o(dat_s)
    );

    pcm_frame_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .stb_i(stb), .lr_i(lr_s),
        .begin_o(beg), .take_o(take), .done_o(done), .done_left_o(done_left),
        .idx_o(idx)
    );

    pcm_sample_asm #(.W(SAMPLE_W), .CNT_W(CNT_W)) asm_i (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .bit_i(dat_s),
        .begin_i(beg), .take_i(take), .done_i(done), .done_left_i(done_left),
        .idx_i(idx), .word_o(word), .word_stb_o(word_stb),
        .word_left_o(word_left)
    );

    // pair the channels: hold left until its right partner closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold_q <= '0;
            have_left_q <= 1'b0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_stb) begin
                if (word_left) begin
                    left_hold_q <= word;
                    have_left_q <= 1'b1;
                end else if (have_left_q) begin
                    left_o      <= left_hold_q;
                    right_o     <= word;
                    valid_o     <= 1'b1;
                    have_left_q <= 1'b0;
                end
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(left_o) && $stable(right_o)); // R6
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_ok($past(fmt_i, 2)) |-> !valid_o); // R8
endmodule

// File: tb/serial_pcm_rx_tb_top.sv
module serial_pcm_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt = 3'd0;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int n_run = 0, n_fail = 0;
    int nval = 0;
    logic [23:0] cap_l = '0, cap_r = '0;
    logic        long_pulse = 1'b0, prev_v = 1'b0;

    always #5 clk = ~clk;

    serial_pcm_rx dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .bclk_i(bclk), .lrclk_i(lrclk),
        .sdata_i(sdata), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    always @(negedge clk) begin
        if (valid_o) begin
            nval++;
            cap_l = left_o;
            cap_r = right_o;
            if (prev_v) long_pulse = 1'b1;
        end
        prev_v = valid_o;
    end

    // vector: fmt[56:54], half bits[53:48], left[47:24], right[23:0]
    localparam int NV = 11;
    localparam logic [56:0] VEC [NV] = '{
        {3'd0, 6'd32, 24'h812345, 24'h7EDCBA},  // R2
        {3'd0, 6'd24, 24'h5A5A5A, 24'hA5A5A5},  // R2
        {3'd0, 6'd16, 24'hC3C3C3, 24'h3C3C3C},  // R5 zero fill
        {3'd1, 6'd32, 24'h876543, 24'h123456},  // R3
        {3'd1, 6'd25, 24'hF0F0F0, 24'h0F0F0F},  // R3
        {3'd2, 6'd32, 24'h00F234, 24'h007ABC},  // R4 16
        {3'd3, 6'd32, 24'h9ABCDE, 24'h13579B},  // R4 24
        {3'd4, 6'd24, 24'h0C1234, 24'h045678},  // R4 20
        {3'd5, 6'd20, 24'h02ABCD, 24'h01ABCD},  // R4 18
        {3'd2, 6'd16, 24'h008001, 24'h007FFF},  // R4 exact width
        {3'd3, 6'd24, 24'h800000, 24'h7FFFFF}   // R4 extremes
    };

    task automatic chk(input logic ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int rjn(input logic [2:0] f);
        case (f) 3'd2: return 16; 3'd3: return 24; 3'd4: return 20; default: return 18; endcase
    endfunction

    function automatic logic bitval(input logic [2:0] f, input int hb, input logic [23:0] s, input int k);
        int j, n;
        if (f == 3'd0) return (k < 24) ? s[23-k] : 1'b1;
        if (f == 3'd1) begin
            j = k - 1;
            return (j >= 0 && j < 24) ? s[23-j] : 1'b1;
        end
        n = rjn(f);
        j = k - (hb - n);
        return (j >= 0) ? s[n-1-j] : 1'b1;
    endfunction

    function automatic logic [23:0] expw(input logic [2:0] f, input int hb, input logic [23:0] s);
        int n;
        logic [23:0] r;
        if (f <= 3'd1) begin
            n = (f == 3'd0) ? hb : hb - 1;
            if (n > 24) n = 24;
            return s & ~(24'hFFFFFF >> n);
        end
        n = rjn(f);
        for (int i = 0; i < 24; i++) r[i] = (i < n) ? s[i] : s[n-1];
        return r;
    endfunction

    task automatic bit_cycle(input logic lr, input logic d);
        @(negedge clk);
        bclk = 1'b0; lrclk = lr; sdata = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_half(input logic lr, input logic [2:0] f, input int hb, input logic [23:0] s);
        for (int k = 0; k < hb; k++) bit_cycle(lr, bitval(f, hb, s, k));
    endtask

    task automatic do_reset(input logic [2:0] f);
        @(negedge clk);
        rst_n = 1'b0; bclk = 1'b0; fmt = f;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_frame(input logic [2:0] f, input int hb, input logic [23:0] l,
                             input logic [23:0] r, input logic lead_left);
        logic ll;
        ll = (f == 3'd1) ? 1'b0 : 1'b1;
        do_reset(f);
        nval = 0;
        if (lead_left) begin
            for (int k = 0; k < 3; k++) bit_cycle(ll, 1'b1);
            send_half(~ll, f, hb, 24'h555555);
        end else begin
            for (int k = 0; k < 3; k++) bit_cycle(~ll, 1'b1);
        end
        send_half(ll, f, hb, l);
        send_half(~ll, f, hb, r);
        for (int k = 0; k < 3; k++) bit_cycle(ll, 1'b0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] f;
        int hb;
        logic [23:0] l, r;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0, "R1 valid", {23'b0, valid_o}, 24'h0);
        chk(left_o == 24'h0, "R1 left", left_o, 24'h0);
        chk(right_o == 24'h0, "R1 right", right_o, 24'h0);

        for (int v = 0; v < NV; v++) begin
            f  = VEC[v][56:54];
            hb = int'(VEC[v][53:48]);
            l  = VEC[v][47:24];
            r  = VEC[v][23:0];
            run_frame(f, hb, l, r, 1'b0);
            chk(nval == 1, "R6 pair count", nval[23:0], 24'd1);
            chk(cap_l == expw(f, hb, l), "R2/R3/R4/R5 left", cap_l, expw(f, hb, l));
            chk(cap_r == expw(f, hb, r), "R2/R3/R4/R5 right", cap_r, expw(f, hb, r));
        end
        chk(long_pulse == 1'b0, "R6 pulse width", {23'b0, long_pulse}, 24'h0);

        // R7: stream opens in a right half with no left before it
        run_frame(3'd0, 32, 24'h246810, 24'hFEDCBA, 1'b1);
        chk(nval == 1, "R7 pair count", nval[23:0], 24'd1);
        chk(cap_l == 24'h246810, "R7 left", cap_l, 24'h246810);
        chk(cap_r == 24'hFEDCBA, "R7 right", cap_r, 24'hFEDCBA);

        // R8: reserved code
        run_frame(3'd6, 32, 24'h111111, 24'h222222, 1'b0);
        chk(nval == 0, "R8 no strobe", nval[23:0], 24'd0);
        chk(left_o == 24'h0 && right_o == 24'h0, "R8 outputs held", left_o | right_o, 24'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule